// File: doc/BRIEF.md
# Dual-Lane Interleaved Fetch Sequencer

This block lets two fetch lanes act as one fetch front end for a single thread running on two fused pipelines. In fused mode the instruction stream is dealt out by position: the first lane emits the instructions at odd sequence positions and the second lane emits those at even positions. Each lane walks the whole predicted path and owns a private gshare predictor. Both lanes see identical inputs, so their predictors and walk state stay bit-identical and they reach the same control decisions without any signal passing between them.

A start pulse loads the entry PC and the mode. In single-lane mode the first lane emits every instruction and the second lane is idle. Each lane reads its own instruction-store port. This port is combinational and also returns a predecode branch flag and a branch target. Each emitted slot carries a sequence number and a stream identifier, so downstream stages can discard wrong-path work when the identifier changes. A shared resolution port trains both predictor copies in the same cycle. When that port reports a mispredict, it also redirects both lanes.

Top module: `dual_fetch_seq`

## Requirements
- R1: After synchronous active-low reset both lanes are inactive, both slot_valid bits are 0 and all slot fields are 0.
- R2: A start pulse loads start_pc, sets the next sequence number to 1, clears the history, increments the stream identifier and latches start_fused; it outranks a same-cycle mispredict. No slot appears at the start edge, and sequence 1 appears one edge later.
- R3: Every active cycle a lane walks one instruction: the next PC is imem_target when the instruction is predicted taken, otherwise PC + 4.
- R4: The predicted direction is 1 only when imem_is_br is 1 and bit 1 of the selected counter is 1. The counter is selected by XOR-folding (PC >> 2) and the 16-bit history into IDX_W bits: bit i of each source goes to index bit i mod IDX_W. All counters reset to 1 (weakly not-taken).
- R5: Each upd_valid cycle moves the counter at the index of upd_pc and upd_hist one step toward upd_taken, saturating at 0 and 3. Both lanes apply it in the same cycle.
- R6: History shifts left with the predicted direction entering bit 0 only for branches; non-branches leave it unchanged. Each slot reports the history in force before its instruction.
- R7: In fused mode lane 0 emits exactly the odd sequence numbers and lane 1 the even ones, one instruction per cycle in total.
- R8: In single-lane mode lane 0 emits every sequence number and lane 1 never asserts slot_valid.
- R9: A mispredict (upd_valid and upd_mispredict) sets PC to upd_target, the next sequence number to upd_seq + 1, history to {upd_hist[14:0], upd_taken} and increments the stream identifier; no slot appears at that edge.
- R10: In fused mode both lanes hold identical PC, history, sequence and identifier, and the merged fused output, ordered by sequence number, equals the single-lane output of the same program.
- R11: A slot carries the PC, the instruction word read at that PC, the sequence number, the stream identifier and the predicted direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start pulse |
| start_pc | input | PC_W | Entry PC |
| start_fused | input | 1 | 1 = fused two-lane mode, 0 = single lane |
| imem_addr | output | 2*PC_W | Per-lane fetch address, lane i at [i*PC_W +: PC_W] |
| imem_instr | input | 2*INSTR_W | Per-lane instruction word |
| imem_is_br | input | 2 | Per-lane predecode branch flag |
| imem_target | input | 2*PC_W | Per-lane predecoded branch target |
| upd_valid | input | 1 | Branch resolution valid |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_hist | input | HIST_W | History used when that branch was predicted |
| upd_taken | input | 1 | Resolved direction |
| upd_mispredict | input | 1 | Resolution disagrees with prediction; redirect |
| upd_target | input | PC_W | Corrected PC |
| upd_seq | input | SEQ_W | Sequence number of the resolved branch |
| slot_valid | output | 2 | Per-lane slot valid |
| slot_pc | output | 2*PC_W | Per-lane slot PC |
| slot_instr | output | 2*INSTR_W | Per-lane slot instruction |
| slot_seq | output | 2*SEQ_W | Per-lane slot sequence number |
| slot_sid | output | 2*SID_W | Per-lane slot stream identifier |
| slot_taken | output | 2 | Per-lane predicted direction |
| slot_hist | output | 2*HIST_W | Per-lane history before the instruction |

## Verification
The bench trains one branch counter past saturation. A predictor without saturation would wrap to strongly not-taken. A predictor without hysteresis would flip after one not-taken update. Both show up as a wrong slot direction on the next start. A directed mispredict checks that the edge is silent and that the next slot carries upd_seq + 1, the corrected PC, the rebuilt history and a new identifier; an off-by-one sequence or a kept stale identifier is reported. The same program is run once in single-lane and once in fused mode, and the two traces are compared by sequence number. A parity swap, a skipped position or a lane whose history drifts breaks that comparison. Random starts, updates and mispredicts then exercise every ordering of those events.

// File: rtl/dfs_pkg.sv
// Shared types and helpers for the dual-lane fetch sequencer.
// Assumes 2-bit saturating direction counters.
package dfs_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

    // Move a counter one step toward the resolved direction, saturating.
    function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic taken);
        if (taken) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        else       return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

endpackage

// File: rtl/dfs_gshare.sv
// Gshare direction table: one read port for the walking lane, one update
// port for branch resolution. The index is the XOR-fold of (PC >> 2) and the
// global history into IDX_W bits. Assumes the update writes at the edge, so
// a same-cycle read sees the old counter.
module dfs_gshare
    import dfs_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 16,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   rd_pc,
    input  logic [HIST_W-1:0] rd_hist,
    output logic [1:0]        rd_ctr,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0]       tab [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] up_idx;

    // Fold the word-aligned PC and the history into one table index.
    function automatic logic [IDX_W-1:0] fold_idx(input logic [PC_W-1:0] pc,
                                                  input logic [HIST_W-1:0] h);
        logic [IDX_W-1:0] r;
        logic [PC_W-1:0]  w;
        r = '0;
        w = pc >> 2;
        for (int i = 0; i < PC_W; i++)   r[i % IDX_W] = r[i % IDX_W] ^ w[i];
        for (int i = 0; i < HIST_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ h[i];
        return r;
    endfunction

    // Index computation for the lookup and the training port.
    always_comb begin
        rd_idx = fold_idx(rd_pc, rd_hist);
        up_idx = fold_idx(upd_pc, upd_hist);
    end

    assign rd_ctr = tab[rd_idx];

    // Counter storage: reset to weakly not-taken, train on resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tab[i] <= CTR_WEAK_NT;
        end else if (upd_valid) begin
            tab[up_idx] <= ctr_next(tab[up_idx], upd_taken);
        end
    end

    // R5: a taken update on a saturated-taken counter leaves it at 3.
    p_ctr_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && tab[up_idx] == 2'd3) |=> tab[$past(up_idx)] == 2'd3);
    // R5: a not-taken update on a saturated-not-taken counter leaves it at 0.
    p_ctr_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && tab[up_idx] == 2'd0) |=> tab[$past(up_idx)] == 2'd0);

endmodule

// File: rtl/dfs_lane.sv
// One fetch lane. It walks the complete predicted instruction path, one
// instruction per active cycle, and emits a slot only for the sequence
// positions it owns. Its predictor is a private copy that receives the same
// training as the other lane's copy. Assumes a combinational instruction
// store that also returns a predecode branch flag and a target.
module dfs_lane
    import dfs_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int HIST_W  = 16,
    parameter int IDX_W   = 10,
    parameter int SEQ_W   = 16,
    parameter int SID_W   = 4,
    parameter int LANE_ID = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    input  logic [PC_W-1:0]    start_pc,
    input  logic               start_fused,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_instr,
    input  logic               imem_is_br,
    input  logic [PC_W-1:0]    imem_target,
    input  logic               upd_valid,
    input  logic [PC_W-1:0]    upd_pc,
    input  logic [HIST_W-1:0]  upd_hist,
    input  logic               upd_taken,
    input  logic               upd_mispredict,
    input  logic [PC_W-1:0]    upd_target,
    input  logic [SEQ_W-1:0]   upd_seq,
    output logic               slot_valid,
    output logic [PC_W-1:0]    slot_pc,
    output logic [INSTR_W-1:0] slot_instr,
    output logic [SEQ_W-1:0]   slot_seq,
    output logic [SID_W-1:0]   slot_sid,
    output logic               slot_taken,
    output logic [HIST_W-1:0]  slot_hist,
    output logic               st_active,
    output logic               st_fused,
    output logic [PC_W-1:0]    st_pc,
    output logic [HIST_W-1:0]  st_hist,
    output logic [SEQ_W-1:0]   st_seq,
    output logic [SID_W-1:0]   st_sid
);
    localparam logic            PRIMARY = (LANE_ID == 0);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);
    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);
    localparam logic [SID_W-1:0] SID_ONE = SID_W'(1);

    logic              active;
    logic              mode_fused;
    logic [PC_W-1:0]   pc;
    logic [HIST_W-1:0] hist;
    logic [SEQ_W-1:0]  seq;
    logic [SID_W-1:0]  sid;

    logic [1:0]        ctr;
    logic              pred_taken;
    logic [PC_W-1:0]   pc_next;
    logic [HIST_W-1:0] hist_next;
    logic              redir;
    logic              owns_seq;

    dfs_gshare #(
        .PC_W   (PC_W),
        .HIST_W (HIST_W),
        .IDX_W  (IDX_W)
    ) u_bp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (pc),
        .rd_hist   (hist),
        .rd_ctr    (ctr),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_hist  (upd_hist),
        .upd_taken (upd_taken)
    );

    assign imem_addr = pc;
    assign redir     = upd_valid & upd_mispredict;

    // Prediction and next walk state for the instruction at the current PC.
    always_comb begin
        pred_taken = imem_is_br & ctr[1];
        pc_next    = pred_taken ? imem_target : pc + PC_STEP;
        hist_next  = imem_is_br ? {hist[HIST_W-2:0], pred_taken} : hist;
    end

    // Ownership: odd positions on lane 0, even on lane 1, all on lane 0 alone.
    always_comb begin
        if (mode_fused) owns_seq = (seq[0] == PRIMARY);
        else            owns_seq = PRIMARY;
    end

    // Walk state: start outranks redirect, redirect outranks the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            mode_fused <= 1'b0;
            pc         <= '0;
            hist       <= '0;
            seq        <= '0;
            sid        <= '0;
        end else if (start_valid) begin
            active     <= PRIMARY | start_fused;
            mode_fused <= start_fused;
            pc         <= start_pc;
            hist       <= '0;
            seq        <= SEQ_ONE;
            sid        <= sid + SID_ONE;
        end else if (redir) begin
            pc   <= upd_target;
            hist <= {upd_hist[HIST_W-2:0], upd_taken};
            seq  <= upd_seq + SEQ_ONE;
            sid  <= sid + SID_ONE;
        end else if (active) begin
            pc   <= pc_next;
            hist <= hist_next;
            seq  <= seq + SEQ_ONE;
        end
    end

    // Output slot register: filled only when this lane owns the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_pc    <= '0;
            slot_instr <= '0;
            slot_seq   <= '0;
            slot_sid   <= '0;
            slot_taken <= 1'b0;
            slot_hist  <= '0;
        end else begin
            slot_valid <= 1'b0;
            if (!start_valid && !redir && active && owns_seq) begin
                slot_valid <= 1'b1;
                slot_pc    <= pc;
                slot_instr <= imem_instr;
                slot_seq   <= seq;
                slot_sid   <= sid;
                slot_taken <= pred_taken;
                slot_hist  <= hist;
            end
        end
    end

    assign st_active = active;
    assign st_fused  = mode_fused;
    assign st_pc     = pc;
    assign st_hist   = hist;
    assign st_seq    = seq;
    assign st_sid    = sid;

    // R7: in fused mode an emitted slot has this lane's parity.
    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && mode_fused) |-> (slot_seq[0] == PRIMARY));
    // R7: in fused mode a lane never emits in two consecutive cycles.
    p_fused_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && mode_fused) |=> !slot_valid);
    // R9: the stream identifier changes only after a start or a mispredict.
    p_sid_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sid) |-> $past(start_valid || redir));
    // R9: the redirect edge produces no slot.
    p_redirect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redir && !start_valid) |=> !slot_valid);

endmodule

// File: rtl/dual_fetch_seq.sv
// Top of the dual-lane fetch sequencer. Two identical lanes receive the same
// start, mode and resolution inputs. Their mirrored state gives consistent
// control flow with no lane-to-lane signals. Per-lane vectors are packed,
// lane i at [i*W +: W].
module dual_fetch_seq #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int HIST_W  = 16,
    parameter int IDX_W   = 10,
    parameter int SEQ_W   = 16,
    parameter int SID_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_valid,
    input  logic [PC_W-1:0]      start_pc,
    input  logic                 start_fused,
    output logic [2*PC_W-1:0]    imem_addr,
    input  logic [2*INSTR_W-1:0] imem_instr,
    input  logic [1:0]           imem_is_br,
    input  logic [2*PC_W-1:0]    imem_target,
    input  logic                 upd_valid,
    input  logic [PC_W-1:0]      upd_pc,
    input  logic [HIST_W-1:0]    upd_hist,
    input  logic                 upd_taken,
    input  logic                 upd_mispredict,
    input  logic [PC_W-1:0]      upd_target,
    input  logic [SEQ_W-1:0]     upd_seq,
    output logic [1:0]           slot_valid,
    output logic [2*PC_W-1:0]    slot_pc,
    output logic [2*INSTR_W-1:0] slot_instr,
    output logic [2*SEQ_W-1:0]   slot_seq,
    output logic [2*SID_W-1:0]   slot_sid,
    output logic [1:0]           slot_taken,
    output logic [2*HIST_W-1:0]  slot_hist
);
    localparam int LANES = 2;

    logic              st_active [LANES];
    logic              st_fused  [LANES];
    logic [PC_W-1:0]   st_pc     [LANES];
    logic [HIST_W-1:0] st_hist   [LANES];
    logic [SEQ_W-1:0]  st_seq    [LANES];
    logic [SID_W-1:0]  st_sid    [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dfs_lane #(
            .PC_W    (PC_W),
            .INSTR_W (INSTR_W),
            .HIST_W  (HIST_W),
            .IDX_W   (IDX_W),
            .SEQ_W   (SEQ_W),
            .SID_W   (SID_W),
            .LANE_ID (g)
        ) u_lane (
            .clk            (clk),
            .rst_n          (rst_n),
            .start_valid    (start_valid),
            .start_pc       (start_pc),
            .start_fused    (start_fused),
            .imem_addr      (imem_addr[g*PC_W +: PC_W]),
            .imem_instr     (imem_instr[g*INSTR_W +: INSTR_W]),
            .imem_is_br     (imem_is_br[g]),
            .imem_target    (imem_target[g*PC_W +: PC_W]),
            .upd_valid      (upd_valid),
            .upd_pc         (upd_pc),
            .upd_hist       (upd_hist),
            .upd_taken      (upd_taken),
            .upd_mispredict (upd_mispredict),
            .upd_target     (upd_target),
            .upd_seq        (upd_seq),
            .slot_valid     (slot_valid[g]),
            .slot_pc        (slot_pc[g*PC_W +: PC_W]),
            .slot_instr     (slot_instr[g*INSTR_W +: INSTR_W]),
            .slot_seq       (slot_seq[g*SEQ_W +: SEQ_W]),
            .slot_sid       (slot_sid[g*SID_W +: SID_W]),
            .slot_taken     (slot_taken[g]),
            .slot_hist      (slot_hist[g*HIST_W +: HIST_W]),
            .st_active      (st_active[g]),
            .st_fused       (st_fused[g]),
            .st_pc          (st_pc[g]),
            .st_hist        (st_hist[g]),
            .st_seq         (st_seq[g]),
            .st_sid         (st_sid[g])
        );
    end

    // R10: with both lanes walking in fused mode their walk state matches.
    p_lockstep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fused[0] && st_active[0] && st_active[1]) |->
        (st_pc[0] == st_pc[1] && st_hist[0] == st_hist[1] && st_seq[0] == st_seq[1]));
    // R10: the stream identifiers of the two lanes never diverge.
    p_sid_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_sid[0] == st_sid[1]);
    // R8: in single-lane mode the second lane stays silent.
    p_single_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_fused[0] |-> !slot_valid[1]);
    // R7: the two lanes never emit in the same cycle.
    p_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_valid) <= 1);

endmodule

// File: tb/test_dual_fetch_seq.sv
`timescale 1ns/1ps
module test_dual_fetch_seq;
    localparam int PW = 32, IW = 32, HW = 16, XW = 10, SW = 16, DW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_valid = 1'b0;
    logic [PW-1:0]   start_pc = '0;
    logic            start_fused = 1'b0;
    logic [2*PW-1:0] imem_addr;
    logic [2*IW-1:0] imem_instr;
    logic [1:0]      imem_is_br;
    logic [2*PW-1:0] imem_target;
    logic            upd_valid = 1'b0;
    logic [PW-1:0]   upd_pc = '0;
    logic [HW-1:0]   upd_hist = '0;
    logic            upd_taken = 1'b0;
    logic            upd_mispredict = 1'b0;
    logic [PW-1:0]   upd_target = '0;
    logic [SW-1:0]   upd_seq = '0;
    logic [1:0]      slot_valid;
    logic [2*PW-1:0] slot_pc;
    logic [2*IW-1:0] slot_instr;
    logic [2*SW-1:0] slot_seq;
    logic [2*DW-1:0] slot_sid;
    logic [1:0]      slot_taken;
    logic [2*HW-1:0] slot_hist;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    // Program image: branch flag, target and word derived from the address.
    function automatic logic [31:0] mix(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ (a >> 13);
    endfunction
    function automatic logic prog_br(input logic [31:0] a);
        logic [31:0] m;
        m = mix(a);
        return m[7:5] < 3'd2;
    endfunction
    function automatic logic [31:0] prog_tgt(input logic [31:0] a);
        logic [31:0] m;
        m = mix(a);
        return {20'd0, m[17:8], 2'b00};
    endfunction
    function automatic logic [31:0] prog_word(input logic [31:0] a);
        return a ^ 32'hC3A5_5A3C;
    endfunction

    assign imem_instr  = {prog_word(imem_addr[63:32]), prog_word(imem_addr[31:0])};
    assign imem_is_br  = {prog_br(imem_addr[63:32]), prog_br(imem_addr[31:0])};
    assign imem_target = {prog_tgt(imem_addr[63:32]), prog_tgt(imem_addr[31:0])};

    dual_fetch_seq i_dual_fetch_seq (.*);

    // Reference model state.
    logic [1:0]    m_tab [1024];
    logic [PW-1:0] m_pc;
    logic [HW-1:0] m_hist;
    logic [SW-1:0] m_seq;
    logic [DW-1:0] m_sid;
    logic          m_active, m_fused;
    logic [1:0]    e_valid;
    logic [PW-1:0] e_pc;
    logic [SW-1:0] e_seq;
    logic [DW-1:0] e_sid;
    logic          e_taken;
    logic [HW-1:0] e_hist;
    logic [31:0]   tr_a [64];
    logic [31:0]   tr_b [64];
    bit            rec_a = 0, rec_b = 0;

    function automatic logic [9:0] idx_of(input logic [31:0] pc, input logic [15:0] h);
        logic [9:0]  r;
        logic [31:0] w;
        r = '0;
        w = pc >> 2;
        for (int i = 0; i < 32; i++) r[i % 10] = r[i % 10] ^ w[i];
        for (int i = 0; i < 16; i++) r[i % 10] = r[i % 10] ^ h[i];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model one clock edge from the inputs currently driven.
    task automatic model_step();
        logic [9:0] ix;
        logic       br, pt;
        int         ln;
        e_valid = 2'b00;
        ix = idx_of(m_pc, m_hist);
        br = prog_br(m_pc);
        pt = br & m_tab[ix][1];
        if (start_valid) begin
            m_fused = start_fused; m_active = 1'b1; m_pc = start_pc;
            m_hist = '0; m_seq = 16'd1; m_sid = m_sid + 4'd1;
        end else if (upd_valid && upd_mispredict) begin
            m_pc = upd_target; m_hist = {upd_hist[14:0], upd_taken};
            m_seq = upd_seq + 16'd1; m_sid = m_sid + 4'd1;
        end else if (m_active) begin
            ln = (m_fused && !m_seq[0]) ? 1 : 0;
            e_valid[ln] = 1'b1;
            e_pc = m_pc; e_seq = m_seq; e_sid = m_sid; e_taken = pt; e_hist = m_hist;
            m_pc = pt ? prog_tgt(m_pc) : m_pc + 32'd4;
            if (br) m_hist = {m_hist[14:0], pt};
            m_seq = m_seq + 16'd1;
        end
        if (upd_valid) begin
            ix = idx_of(upd_pc, upd_hist);
            if (upd_taken) m_tab[ix] = (m_tab[ix] == 2'd3) ? 2'd3 : m_tab[ix] + 2'd1;
            else           m_tab[ix] = (m_tab[ix] == 2'd0) ? 2'd0 : m_tab[ix] - 2'd1;
        end
    endtask

    task automatic compare();
        string rq;
        for (int l = 0; l < 2; l++) begin
            rq = m_fused ? "R7" : "R8";
            chk(slot_valid[l] == e_valid[l], rq, $sformatf("lane%0d valid", l),
                64'(slot_valid[l]), 64'(e_valid[l]));
            if (e_valid[l] && slot_valid[l]) begin
                chk(slot_pc[l*32 +: 32] == e_pc, "R3", "pc", 64'(slot_pc[l*32 +: 32]), 64'(e_pc));
                chk(slot_instr[l*32 +: 32] == prog_word(e_pc), "R11", "instr",
                    64'(slot_instr[l*32 +: 32]), 64'(prog_word(e_pc)));
                chk(slot_seq[l*16 +: 16] == e_seq, rq, "seq", 64'(slot_seq[l*16 +: 16]), 64'(e_seq));
                chk(slot_sid[l*4 +: 4] == e_sid, "R2", "sid", 64'(slot_sid[l*4 +: 4]), 64'(e_sid));
                chk(slot_taken[l] == e_taken, "R4", "taken", 64'(slot_taken[l]), 64'(e_taken));
                chk(slot_hist[l*16 +: 16] == e_hist, "R6", "hist", 64'(slot_hist[l*16 +: 16]), 64'(e_hist));
                if (e_seq < 16'd64) begin
                    if (rec_a) tr_a[e_seq[5:0]] = slot_pc[l*32 +: 32];
                    if (rec_b) tr_b[e_seq[5:0]] = slot_pc[l*32 +: 32];
                end
            end
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_start(input logic [31:0] pc, input logic fused);
        start_valid = 1'b1; start_pc = pc; start_fused = fused;
        tick();
        start_valid = 1'b0;
    endtask

    task automatic train(input logic [31:0] pc, input logic tk, input int n);
        for (int i = 0; i < n; i++) begin
            upd_valid = 1'b1; upd_pc = pc; upd_hist = '0; upd_taken = tk; upd_mispredict = 1'b0;
            tick();
        end
        upd_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] bpc;
        logic [DW-1:0] sid0;
        void'($urandom(32'd20101207));
        for (int i = 0; i < 1024; i++) m_tab[i] = 2'd1;
        m_pc = '0; m_hist = '0; m_seq = '0; m_sid = '0; m_active = 0; m_fused = 0; e_valid = '0;
        for (int i = 0; i < 64; i++) begin tr_a[i] = '1; tr_b[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk(slot_valid == 2'b00, "R1", "slot_valid", 64'(slot_valid), 64'd0);
        chk(slot_seq == '0, "R1", "slot_seq", 64'(slot_seq), 64'd0);

        // R2: start edge is silent, sequence 1 follows at start_pc.
        rec_a = 1;
        do_start(32'h100, 1'b0);
        chk(slot_valid == 2'b00, "R2", "start edge slot", 64'(slot_valid), 64'd0);
        tick();
        chk(slot_valid[0] && slot_seq[15:0] == 16'd1 && slot_pc[31:0] == 32'h100, "R2",
            "first slot pc", 64'(slot_pc[31:0]), 64'h100);
        repeat (45) tick();
        rec_a = 0;

        // R10: fused run of the same program matches the single-lane trace.
        rec_b = 1;
        do_start(32'h100, 1'b1);
        repeat (46) tick();
        rec_b = 0;
        for (int s = 1; s <= 40; s++)
            chk(tr_a[s] == tr_b[s], "R10", $sformatf("trace seq %0d", s), 64'(tr_b[s]), 64'(tr_a[s]));

        // R9: mispredict redirect.
        sid0 = slot_sid[3:0] | slot_sid[7:4];
        upd_valid = 1; upd_mispredict = 1; upd_seq = 16'h0050; upd_target = 32'h200;
        upd_hist = 16'h00F0; upd_taken = 1; upd_pc = 32'h180;
        tick();
        upd_valid = 0; upd_mispredict = 0;
        chk(slot_valid == 2'b00, "R9", "redirect edge slot", 64'(slot_valid), 64'd0);
        tick();
        chk(slot_valid[0] && slot_seq[15:0] == 16'h0051, "R9", "redirect seq", 64'(slot_seq[15:0]), 64'h51);
        chk(slot_pc[31:0] == 32'h200, "R9", "redirect pc", 64'(slot_pc[31:0]), 64'h200);
        chk(slot_hist[15:0] == 16'h01E1, "R9", "redirect hist", 64'(slot_hist[15:0]), 64'h1E1);
        chk(slot_sid[3:0] == sid0 + 4'd1, "R9", "redirect sid", 64'(slot_sid[3:0]), 64'(sid0 + 4'd1));

        // R4/R5: saturation and hysteresis of one branch counter.
        bpc = 32'h40;
        while (!prog_br(bpc)) bpc = bpc + 32'd4;
        train(bpc, 1'b1, 4);
        do_start(bpc, 1'b0); tick();
        chk(slot_taken[0] == 1'b1, "R4", "trained taken", 64'(slot_taken[0]), 64'd1);
        tick();
        chk(slot_pc[31:0] == prog_tgt(bpc), "R3", "taken target", 64'(slot_pc[31:0]), 64'(prog_tgt(bpc)));
        train(bpc, 1'b0, 1);
        do_start(bpc, 1'b0); tick();
        chk(slot_taken[0] == 1'b1, "R5", "hysteresis", 64'(slot_taken[0]), 64'd1);
        train(bpc, 1'b0, 5);
        do_start(bpc, 1'b0); tick();
        chk(slot_taken[0] == 1'b0, "R5", "saturated not-taken", 64'(slot_taken[0]), 64'd0);
        chk(slot_valid[1] == 1'b0, "R8", "lane1 idle", 64'(slot_valid[1]), 64'd0);

        // Random mix of starts, training and mispredicts.
        for (int c = 0; c < 4000; c++) begin
            start_valid = ($urandom % 150) == 0;
            start_pc = {20'd0, 10'($urandom), 2'b00};
            start_fused = 1'($urandom);
            upd_valid = ($urandom % 4) == 0;
            upd_mispredict = ($urandom % 8) == 0;
            upd_pc = {20'd0, 10'($urandom), 2'b00};
            upd_hist = 16'($urandom);
            upd_taken = 1'($urandom);
            upd_target = {20'd0, 10'($urandom), 2'b00};
            upd_seq = 16'($urandom);
            tick();
        end
        start_valid = 0; upd_valid = 0; upd_mispredict = 0;
        tick();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule